// File: doc/BRIEF.md
# Bit-Serial Crossbar Partial-Sum Accumulator

This block is the digital back end of an in-memory dot-product engine. An analog crossbar computes a 16-bit signed input vector against 16-bit weights. The input is applied one bit per step, least significant bit first. Each weight is split into eight 2-bit slices, and each slice sits in its own column. On every step the block receives three things: one 8-bit digitized reading per slice column, the count of rows whose input bit is 1 in that step, and a mask saying which columns hold their cells in complemented form.

For each step the block does the following:
- It undoes the complemented encoding.
- It merges the eight slice readings with shift-and-add.
- It removes the offset that the weights carry, because they are stored as unsigned values with a bias of 32768.
- It accumulates the step's term at the step's bit position. The sixteenth step is subtracted, because it carries the sign bit of the input.

After the sixteenth accepted step, the block delivers the signed dot product, clamped to 32 bits, together with a one-cycle done strobe. A start pulse begins a new product at any time.

Top module: `xbar_psum_accum`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done` is 0 and `result` is 0.
- R2: A column whose `flip_mask` bit is 0 contributes its reading unchanged. Slice k (bits 8k+7..8k of `col_reading`) is weighted by 4^k.
- R3: A column whose `flip_mask` bit is 1 contributes 3 × `row_popcount` − reading instead of the reading.
- R4: Steps are taken LSB first. Accepted step n (0..15) is weighted by 2^n. `done` rises in the cycle after the sixteenth accepted step.
- R5: The term of the sixteenth step is subtracted from the accumulator, not added.
- R6: Each step's term has 32768 × `row_popcount` removed before it is shifted. This makes the result equal to the sum of (signed input × (stored weight − 32768)).
- R7: A product above 2^31−1 returns 0x7FFFFFFF. A product below −2^31 returns 0x80000000.
- R8: `start` clears any product in progress. Steps accepted before it do not contribute, and no `done` follows them. If `start` and `iter_valid` are both high in the same cycle, `start` wins.
- R9: `iter_valid` while no product is in progress is ignored: `done` stays 0 and `result` is unchanged.
- R10: `done` is a single-cycle pulse. `result` changes only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new product and clear the accumulator |
| iter_valid | input | 1 | One input-bit step is presented this cycle |
| col_reading | input | 64 | Eight 8-bit slice readings; slice k at bits 8k+7..8k |
| flip_mask | input | 8 | Bit k set: slice k column is stored complemented |
| row_popcount | input | 8 | Number of rows with an active input bit this step |
| done | output | 1 | One-cycle strobe: result is new |
| result | output | 32 | Saturated signed dot product |

## Verification
Most internal faults show up only as a wrong `result` at the next `done`, sixteen accepted steps after `start`. Examples are a wrong slice weight, a missing complement recovery, a wrong bias sign, or a wrong shift. A fault in the step counter shows as `done` arriving on the wrong step or never arriving. Products are therefore checked one at a time against a model of weights and inputs, with flip masks chosen in several ways. Saturation, abort and idle-step cases are also applied, because each of them sets the value of a single product.

// File: rtl/xbar_psum_accum.sv
module xbar_psum_accum #(
  parameter int SLICES     = 8,
  parameter int SLICE_BITS = 2,
  parameter int RD_W       = 8,
  parameter int PC_W       = 8,
  parameter int IN_BITS    = 16,
  parameter int ACC_W      = 48,
  parameter int OUT_W      = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    iter_valid,
  input  logic [SLICES*RD_W-1:0]  col_reading,
  input  logic [SLICES-1:0]       flip_mask,
  input  logic [PC_W-1:0]         row_popcount,
  output logic                    done,
  output logic signed [OUT_W-1:0] result
);
  localparam int CNT_W   = $clog2(IN_BITS);
  localparam int BIAS_SH = SLICES*SLICE_BITS - 1;
  localparam logic signed [ACC_W-1:0] CELL_MAX = ACC_W'((1 << SLICE_BITS) - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI   = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SAT_LO   = -SAT_HI - ACC_W'(1);
  localparam logic [CNT_W-1:0]        LAST     = CNT_W'(IN_BITS - 1);

  logic                    busy;
  logic [CNT_W-1:0]        iter_cnt;
  logic signed [ACC_W-1:0] acc;

  logic signed [ACC_W-1:0] pop_s;
  logic signed [ACC_W-1:0] part [SLICES+1];
  logic signed [ACC_W-1:0] step_term, step_shift, acc_nx, sat_val;
  logic                    take, last_step;

  assign pop_s   = $signed({{(ACC_W-PC_W){1'b0}}, row_popcount});
  assign part[0] = '0;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    logic signed [ACC_W-1:0] rd_s, col_s;
    assign rd_s  = $signed({{(ACC_W-RD_W){1'b0}}, col_reading[k*RD_W +: RD_W]});
    assign col_s = flip_mask[k] ? (pop_s * CELL_MAX - rd_s) : rd_s;
    assign part[k+1] = part[k] + (col_s <<< (SLICE_BITS*k));
  end

  assign step_term  = part[SLICES] - (pop_s <<< BIAS_SH);
  assign step_shift = step_term <<< iter_cnt;
  assign last_step  = (iter_cnt == LAST);
  assign acc_nx     = last_step ? acc - step_shift : acc + step_shift;
  assign sat_val    = (acc_nx > SAT_HI) ? SAT_HI : (acc_nx < SAT_LO) ? SAT_LO : acc_nx;
  assign take       = busy && iter_valid && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      iter_cnt <= '0;
      acc      <= '0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        iter_cnt <= '0;
        acc      <= '0;
      end else if (take) begin
        acc <= acc_nx;
        if (last_step) begin
          busy     <= 1'b0;
          iter_cnt <= '0;
          done     <= 1'b1;
          result   <= sat_val[OUT_W-1:0];
        end else begin
          iter_cnt <= iter_cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R10
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && iter_cnt == '0 && !done)); // R8
  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && iter_valid) |=> !done); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && iter_valid && !start && iter_cnt == LAST) |=> (done && !busy)); // R4
endmodule

// File: tb/xbar_psum_accum_bench.sv
`timescale 1ns/1ps
module xbar_psum_accum_bench;
  localparam int ROWS = 128;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, iter_valid = 1'b0;
  logic [63:0] col_reading = '0;
  logic [7:0]  flip_mask = '0, row_popcount = '0;
  logic        done;
  logic signed [31:0] result;

  int wt  [ROWS];
  int xin [ROWS];
  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  xbar_psum_accum u_xbar_psum_accum (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_valid(iter_valid),
    .col_reading(col_reading), .flip_mask(flip_mask), .row_popcount(row_popcount),
    .done(done), .result(result));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint exp_dot();
    longint s = 0;
    for (int r = 0; r < ROWS; r++) s += longint'(xin[r]) * longint'(wt[r]);
    return sat32(s);
  endfunction

  // pol: 0 flip only when needed, 1 flip whenever it fits, 2 random
  task automatic drive_iter(input int b, input int pol);
    int pop = 0;
    for (int r = 0; r < ROWS; r++) if ((xin[r] >> b) & 1) pop++;
    for (int k = 0; k < 8; k++) begin
      int s = 0, rd;
      bit fl;
      for (int r = 0; r < ROWS; r++)
        if ((xin[r] >> b) & 1) s += ((wt[r] + 32768) >> (2*k)) & 3;
      if (s > 255) fl = 1'b1;
      else if (3*pop - s > 255) fl = 1'b0;
      else if (pol == 1) fl = 1'b1;
      else if (pol == 2) fl = bit'($urandom_range(0, 1));
      else fl = 1'b0;
      rd = fl ? 3*pop - s : s;
      col_reading[8*k +: 8] = 8'(rd);
      flip_mask[k] = fl;
    end
    row_popcount = 8'(pop);
    iter_valid = 1'b1;
    @(negedge clk);
    iter_valid = 1'b0;
    col_reading = 64'(longint'($urandom()) << 32 | longint'($urandom()));
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_dot(input string req, input int pol, input bit gaps);
    longint e = exp_dot();
    longint prev;
    pulse_start();
    for (int b = 0; b < 16; b++) begin
      if (gaps && $urandom_range(0, 3) == 0) @(negedge clk);
      prev = longint'(result);
      drive_iter(b, pol);
      if (b < 15) check(!done, {req, " R4 no early done"}, done, 0);
    end
    check(done === 1'b1, {req, " R4 done"}, done, 1);
    check(longint'(result) == e, req, longint'(result), e);
    @(negedge clk);
    check(!done, {req, " R10 pulse"}, done, 0);
    check(longint'(result) == e, {req, " R10 hold"}, longint'(result), e);
  endtask

  task automatic fill(input int wlo, input int whi, input int xlo, input int xhi, input int density);
    for (int r = 0; r < ROWS; r++) begin
      wt[r]  = int'($urandom_range(0, whi - wlo)) + wlo;
      xin[r] = ($urandom_range(0, 99) < density) ? int'($urandom_range(0, xhi - xlo)) + xlo : 0;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    longint hold;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!done && result == 0, "R1 reset", longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && result == 0, "R1 after reset", longint'(result), 0);

    // R2: small positive inputs, no flipping
    fill(0, 200, 0, 15, 30);
    run_dot("R2 unflipped", 0, 1'b0);
    // R3: same pattern with maximal flipping
    run_dot("R3 flipped", 1, 1'b0);
    // R4: single row, single bit positions
    for (int r = 0; r < ROWS; r++) begin wt[r] = 0; xin[r] = 0; end
    wt[5] = 1234; xin[5] = 16'h0400;
    run_dot("R4 bit position", 2, 1'b1);
    // R5: negative inputs
    fill(-32768, 32767, -32768, -1, 40);
    run_dot("R5 negative inputs", 2, 1'b0);
    for (int r = 0; r < ROWS; r++) begin wt[r] = 0; xin[r] = 0; end
    wt[0] = 7; xin[0] = -1;
    run_dot("R5 minus one", 1, 1'b0);
    // R6: zero weights with dense input cancel the bias
    for (int r = 0; r < ROWS; r++) begin wt[r] = 0; xin[r] = int'($urandom_range(0, 65535)) - 32768; end
    run_dot("R6 bias removal", 2, 1'b0);
    // R7: saturation
    for (int r = 0; r < ROWS; r++) begin wt[r] = -32768; xin[r] = -32768; end
    run_dot("R7 sat high", 0, 1'b0);
    for (int r = 0; r < ROWS; r++) begin wt[r] = 32767; xin[r] = -32768; end
    run_dot("R7 sat low", 2, 1'b0);

    // R8: abort mid computation
    fill(-32768, 32767, -32768, 32767, 90);
    pulse_start();
    for (int b = 0; b < 7; b++) drive_iter(b, 2);
    check(!done, "R8 no done before abort", done, 0);
    fill(-3000, 3000, -32768, 32767, 60);
    run_dot("R8 after abort", 2, 1'b0);
    // R8: start together with iter_valid
    pulse_start();
    for (int b = 0; b < 4; b++) drive_iter(b, 0);
    start = 1'b1; iter_valid = 1'b1;
    @(negedge clk);
    start = 1'b0; iter_valid = 1'b0;
    for (int b = 0; b < 16; b++) drive_iter(b, 2);
    check(done === 1'b1, "R8 start wins done", done, 1);
    check(longint'(result) == exp_dot(), "R8 start wins", longint'(result), exp_dot());

    // R9: steps while idle
    @(negedge clk);
    hold = longint'(result);
    for (int b = 0; b < 20; b++) begin
      drive_iter(b % 16, 2);
      check(!done, "R9 idle no done", done, 0);
    end
    check(longint'(result) == hold, "R9 idle result", longint'(result), hold);

    // random mix
    for (int t = 0; t < 40; t++) begin
      case (t % 4)
        0: fill(-32768, 32767, -32768, 32767, 50);
        1: fill(-500, 500, -32768, 32767, 100);
        2: fill(-32768, 32767, 0, 255, 80);
        default: fill(0, 65535 - 32768, -32768, 32767, 20);
      endcase
      run_dot("R2 R3 R5 R6 random", t % 3, bit'(t & 1));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule